// File: doc/BRIEF.md
# Linear CCD Line Segmenter with Per-Channel Black Clamp

The block sits behind the digitizers of a two-channel linear CCD. Every sample arrives on one of two channels. The odd channel carries odd-numbered line positions and the even channel carries even-numbered ones. Each sample comes with the position number that the timing generator assigned to it. The block checks that positions arrive in sequence. It sorts each position into the leading dummy/optical-black section, the effective section or the trailing dummy section.

While the leading section passes, each channel collects ten optical-black samples at its own fixed interleaved positions. It forms a rounded mean from them with a reciprocal multiply. That mean is then subtracted from every effective pixel of the same line on that channel, and the result is clamped to the code range. Only effective pixels leave the block, each numbered from 1. The output lane identifies the channel, and two markers flag the first and the last effective pixel of the line.

A line begins with a one-cycle line-start pulse on a cycle that carries no samples. The two channels may arrive in the same cycle (simultaneous timing), or the even channel may trail the odd channel by one cycle in an overlapped pattern (alternate timing). Both timings are accepted without configuration. Missing, skipped or early-ended data raises a sticky error flag. The affected channel then waits for the next line start.

Top module: `ccd_line_segmenter`

## Requirements
- R1: A line holds 5244 positions numbered from 1. Positions 1 to 74 are the leading section, 75 to 5224 are effective pixels S1 to S5224-74 (S1 to S5150), and 5225 to 5244 are the trailing section.
- R2: Only odd positions are taken from the odd channel and only even positions from the even channel. Effective pixels with odd numbers therefore appear only on the odd output lane, and those with even numbers only on the even output lane.
- R3: The odd black mean is built from positions 5, 7, …, 23, and the even black mean from positions 6, 8, …, 24, ten samples each. The mean is floor((sum + 5) / 10), which rounds halves upward. Samples at all other leading positions have no influence.
- R4: Each effective output equals the sample minus its channel's black mean of the same line, clamped to 0 below and to 4095 above (12-bit codes).
- R5: An output lane asserts its valid flag only for effective positions. The pixel number it reports is the position minus 74.
- R6: The start marker is high together with pixel 1 on the odd lane, and the end marker is high together with pixel 5150 on the even lane. Neither marker is high in any other cycle.
- R7: Simultaneous timing (both channels in one cycle) and alternate timing (even channel one cycle behind, overlapped) give identical output values.
- R8: A channel sample whose position differs from the next expected one, or a line start arriving before both channels have delivered their last position, sets the error flag. The flag stays set until reset.
- R9: After an error, the affected channel emits nothing until the next line start. From that line start it processes normally. Samples arriving before the first line start after reset are ignored.
- R10: During and right after reset, both valid flags, both markers and the error flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse before position 1 of a line |
| odd_vld | input | 1 | Odd-channel sample valid |
| odd_pos | input | 13 | Odd-channel line position |
| odd_data | input | 12 | Odd-channel sample |
| even_vld | input | 1 | Even-channel sample valid |
| even_pos | input | 13 | Even-channel line position |
| even_data | input | 12 | Even-channel sample |
| out_odd_vld | output | 1 | Odd-lane corrected pixel valid |
| out_odd_num | output | 13 | Odd-lane effective pixel number |
| out_odd_data | output | 12 | Odd-lane corrected pixel |
| out_even_vld | output | 1 | Even-lane corrected pixel valid |
| out_even_num | output | 13 | Even-lane effective pixel number |
| out_even_data | output | 12 | Even-lane corrected pixel |
| out_sol | output | 1 | First effective pixel marker |
| out_eol | output | 1 | Last effective pixel marker |
| seq_err | output | 1 | Sticky sequence error |

## Verification
Full lines are driven in simultaneous and in alternate timing with the same black pattern. Any difference between the two exposes a channel that is tied to slot alignment. Black patterns of all zero, all full scale, a varied set and a set whose exact mean ends in one half separate correct clamping from wrap-around and rounding from truncation. Junk values at the leading positions outside the black windows reveal a wrong window. A skipped odd position, an early line start and samples sent before any line start show that the error is sticky, that it is confined to one channel and that processing restarts on the next line.

// File: rtl/lseg_pkg.sv
package lseg_pkg;

  // Rounded division by a constant: (sum + n/2) * recip >> shift
  function automatic logic [31:0] mean_round(input logic [31:0] sum,
                                             input logic [31:0] n,
                                             input logic [31:0] recip,
                                             input int unsigned shift);
    logic [63:0] prod;
    prod = (64'(sum) + 64'(n >> 1)) * 64'(recip);
    return 32'(prod >> shift);
  endfunction

  // Sample minus black level, clamped into [0, maxc]
  function automatic logic [31:0] clamp_sub(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [31:0] maxc);
    if (b >= a) return 32'd0;
    else if ((a - b) > maxc) return maxc;
    else return a - b;
  endfunction

endpackage

// File: rtl/lseg_seq_track.sv
module lseg_seq_track #(
  parameter int POS_W   = 13,
  parameter int DW      = 12,
  parameter int N_TOTAL = 5244,
  parameter int PAR     = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             in_vld,
  input  logic [POS_W-1:0] in_pos,
  input  logic [DW-1:0]    in_data,
  output logic             acc_vld,
  output logic [POS_W-1:0] acc_pos,
  output logic [DW-1:0]    acc_data,
  output logic             seq_err
);
  localparam logic [POS_W-1:0] FIRST_POS = POS_W'(1 + PAR);
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(N_TOTAL - 1 + PAR);
  localparam logic             ODD_LSB   = (PAR == 0);

  logic             active;
  logic [POS_W-1:0] exp_pos;
  logic             order_ok;
  logic             bad_order;
  logic             early_end;

  assign order_ok  = (in_pos == exp_pos);
  assign acc_vld   = in_vld && active && !line_start && order_ok;
  assign bad_order = in_vld && active && !line_start && !order_ok;
  assign early_end = line_start && active;
  assign seq_err   = bad_order || early_end;
  assign acc_pos   = in_pos;
  assign acc_data  = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      exp_pos <= FIRST_POS;
    end else if (line_start) begin
      active  <= 1'b1;
      exp_pos <= FIRST_POS;
    end else if (bad_order) begin
      active  <= 1'b0;
    end else if (acc_vld) begin
      exp_pos <= exp_pos + POS_W'(2);
      if (in_pos == LAST_POS) active <= 1'b0;
    end
  end

  // R2: accepted positions carry this channel's parity
  assert_chan_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_vld |-> (acc_pos[0] == ODD_LSB));

  // R9: an error stops the channel until a line start
  assert_halt_after_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !line_start) |=> !acc_vld);

endmodule

// File: rtl/lseg_black_avg.sv
module lseg_black_avg #(
  parameter int POS_W     = 13,
  parameter int DW        = 12,
  parameter int BLK_FIRST = 5,
  parameter int BLK_N     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc_vld,
  input  logic [POS_W-1:0] acc_pos,
  input  logic [DW-1:0]    acc_data,
  output logic [DW-1:0]    mean,
  output logic             mean_rdy
);
  import lseg_pkg::*;

  localparam int             SUM_W   = DW + $clog2(BLK_N + 1);
  localparam int             CNT_W   = $clog2(BLK_N + 1);
  localparam int             RSHIFT  = SUM_W + $clog2(BLK_N);
  localparam logic [63:0]    RECIP64 = ((64'd1 << RSHIFT) + 64'(BLK_N) - 64'd1) / 64'(BLK_N);
  localparam logic [31:0]    RECIP   = RECIP64[31:0];
  localparam int             BLK_LAST = BLK_FIRST + 2 * (BLK_N - 1);

  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] sum_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             is_blk;
  logic             take;
  logic [31:0]      mean_full;

  assign is_blk    = (acc_pos >= POS_W'(BLK_FIRST)) && (acc_pos <= POS_W'(BLK_LAST));
  assign take      = acc_vld && is_blk && !mean_rdy;
  assign sum_nx    = sum_q + SUM_W'(acc_data);
  assign mean_full = mean_round(32'(sum_nx), 32'(BLK_N), RECIP, RSHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q    <= '0;
      cnt_q    <= '0;
      mean     <= '0;
      mean_rdy <= 1'b0;
    end else if (clr) begin
      sum_q    <= '0;
      cnt_q    <= '0;
      mean_rdy <= 1'b0;
    end else if (take) begin
      sum_q <= sum_nx;
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(BLK_N - 1)) begin
        mean     <= mean_full[DW-1:0];
        mean_rdy <= 1'b1;
      end
    end
  end

  // R3: the mean becomes ready only on the last of BLK_N samples
  assert_mean_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mean_rdy) |-> ($past(cnt_q) == CNT_W'(BLK_N - 1)));

  // R3: never more than BLK_N samples collected
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BLK_N));

endmodule

// File: rtl/lseg_correct.sv
module lseg_correct #(
  parameter int POS_W  = 13,
  parameter int DW     = 12,
  parameter int N_LEAD = 74,
  parameter int N_EFF  = 5150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic [POS_W-1:0] acc_pos,
  input  logic [DW-1:0]    acc_data,
  input  logic [DW-1:0]    mean,
  input  logic             mean_rdy,
  output logic             o_vld,
  output logic [POS_W-1:0] o_num,
  output logic [DW-1:0]    o_data,
  output logic             o_first,
  output logic             o_last
);
  import lseg_pkg::*;

  localparam logic [31:0] MAXC = 32'((64'd1 << DW) - 64'd1);

  logic        is_eff;
  logic        emit;
  logic [31:0] corr;

  assign is_eff = (acc_pos > POS_W'(N_LEAD)) && (acc_pos <= POS_W'(N_LEAD + N_EFF));
  assign emit   = acc_vld && is_eff;
  assign corr   = clamp_sub(32'(acc_data), 32'(mean), MAXC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld   <= 1'b0;
      o_num   <= '0;
      o_data  <= '0;
      o_first <= 1'b0;
      o_last  <= 1'b0;
    end else begin
      o_vld   <= emit;
      o_first <= emit && (acc_pos == POS_W'(N_LEAD + 1));
      o_last  <= emit && (acc_pos == POS_W'(N_LEAD + N_EFF));
      if (emit) begin
        o_num  <= acc_pos - POS_W'(N_LEAD);
        o_data <= corr[DW-1:0];
      end
    end
  end

  // R3: the black mean is complete before any effective pixel
  assert_black_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> mean_rdy);

  // R5: emitted numbers stay inside the effective range
  assert_num_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |-> ((o_num >= POS_W'(1)) && (o_num <= POS_W'(N_EFF))));

  // R4: subtraction never raises a pixel above its raw sample
  assert_no_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld |-> (o_data <= $past(acc_data)));

  // R6: markers only ride on valid pixels
  assert_marker_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_first || o_last) |-> o_vld);

endmodule

// File: rtl/ccd_line_segmenter.sv
module ccd_line_segmenter #(
  parameter int DW        = 12,
  parameter int N_LEAD    = 74,
  parameter int N_EFF     = 5150,
  parameter int N_TRAIL   = 20,
  parameter int BLK_FIRST = 5,
  parameter int BLK_N     = 10,
  localparam int N_TOTAL  = N_LEAD + N_EFF + N_TRAIL,
  localparam int POS_W    = $clog2(N_TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             odd_vld,
  input  logic [POS_W-1:0] odd_pos,
  input  logic [DW-1:0]    odd_data,
  input  logic             even_vld,
  input  logic [POS_W-1:0] even_pos,
  input  logic [DW-1:0]    even_data,
  output logic             out_odd_vld,
  output logic [POS_W-1:0] out_odd_num,
  output logic [DW-1:0]    out_odd_data,
  output logic             out_even_vld,
  output logic [POS_W-1:0] out_even_num,
  output logic [DW-1:0]    out_even_data,
  output logic             out_sol,
  output logic             out_eol,
  output logic             seq_err
);
  localparam int N_CH = 2;

  logic             in_vld   [N_CH];
  logic [POS_W-1:0] in_pos   [N_CH];
  logic [DW-1:0]    in_data  [N_CH];
  logic             acc_vld  [N_CH];
  logic [POS_W-1:0] acc_pos  [N_CH];
  logic [DW-1:0]    acc_data [N_CH];
  logic             ch_err   [N_CH];
  logic [DW-1:0]    blk_mean [N_CH];
  logic             blk_rdy  [N_CH];
  logic             o_vld    [N_CH];
  logic [POS_W-1:0] o_num    [N_CH];
  logic [DW-1:0]    o_data   [N_CH];
  logic             o_first  [N_CH];
  logic             o_last   [N_CH];
  logic             err_event;
  logic             err_q;

  assign in_vld[0]  = odd_vld;
  assign in_pos[0]  = odd_pos;
  assign in_data[0] = odd_data;
  assign in_vld[1]  = even_vld;
  assign in_pos[1]  = even_pos;
  assign in_data[1] = even_data;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    lseg_seq_track #(
      .POS_W(POS_W), .DW(DW), .N_TOTAL(N_TOTAL), .PAR(c)
    ) u_track (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .in_vld(in_vld[c]), .in_pos(in_pos[c]), .in_data(in_data[c]),
      .acc_vld(acc_vld[c]), .acc_pos(acc_pos[c]), .acc_data(acc_data[c]),
      .seq_err(ch_err[c])
    );

    lseg_black_avg #(
      .POS_W(POS_W), .DW(DW), .BLK_FIRST(BLK_FIRST + c), .BLK_N(BLK_N)
    ) u_black (
      .clk(clk), .rst_n(rst_n), .clr(line_start),
      .acc_vld(acc_vld[c]), .acc_pos(acc_pos[c]), .acc_data(acc_data[c]),
      .mean(blk_mean[c]), .mean_rdy(blk_rdy[c])
    );

    lseg_correct #(
      .POS_W(POS_W), .DW(DW), .N_LEAD(N_LEAD), .N_EFF(N_EFF)
    ) u_corr (
      .clk(clk), .rst_n(rst_n),
      .acc_vld(acc_vld[c]), .acc_pos(acc_pos[c]), .acc_data(acc_data[c]),
      .mean(blk_mean[c]), .mean_rdy(blk_rdy[c]),
      .o_vld(o_vld[c]), .o_num(o_num[c]), .o_data(o_data[c]),
      .o_first(o_first[c]), .o_last(o_last[c])
    );
  end

  assign err_event = ch_err[0] || ch_err[1];

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (err_event) err_q <= 1'b1;
  end

  assign out_odd_vld   = o_vld[0];
  assign out_odd_num   = o_num[0];
  assign out_odd_data  = o_data[0];
  assign out_even_vld  = o_vld[1];
  assign out_even_num  = o_num[1];
  assign out_even_data = o_data[1];
  assign out_sol       = o_first[0] || o_first[1];
  assign out_eol       = o_last[0] || o_last[1];
  assign seq_err       = err_q;

  // R8: the error flag never clears outside reset
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  // R8: every channel error event reaches the flag
  assert_err_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> seq_err);

  // R6: start and end markers are never raised together
  assert_markers_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sol && out_eol));

endmodule

// File: tb/ccd_line_segmenter_tb.sv
module ccd_line_segmenter_tb;
  localparam int N_LEAD  = 74;
  localparam int N_EFF   = 5150;
  localparam int N_TOTAL = 5244;
  localparam int POS_W   = 13;
  localparam int DW      = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic odd_vld = 1'b0, even_vld = 1'b0;
  logic [POS_W-1:0] odd_pos = '0, even_pos = '0;
  logic [DW-1:0] odd_data = '0, even_data = '0;
  logic out_odd_vld, out_even_vld, out_sol, out_eol, seq_err;
  logic [POS_W-1:0] out_odd_num, out_even_num;
  logic [DW-1:0] out_odd_data, out_even_data;

  always #10 clk = ~clk;

  ccd_line_segmenter u_dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .odd_vld(odd_vld), .odd_pos(odd_pos), .odd_data(odd_data),
    .even_vld(even_vld), .even_pos(even_pos), .even_data(even_data),
    .out_odd_vld(out_odd_vld), .out_odd_num(out_odd_num), .out_odd_data(out_odd_data),
    .out_even_vld(out_even_vld), .out_even_num(out_even_num), .out_even_data(out_even_data),
    .out_sol(out_sol), .out_eol(out_eol), .seq_err(seq_err)
  );

  typedef struct { int num; int data; bit mark; } item_t;
  item_t q_odd[$];
  item_t q_even[$];
  int checks = 0;
  int errors = 0;
  string tag = "R10";
  int cur_kind = 0;
  int cur_seed = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sample_val(input int kind, input int seed, input int p);
    if (p >= 5 && p <= 24) begin
      case (kind)
        0: return 100 + (p % 7) * 3;
        1: return 4095;
        2: return 0;
        default: return 4 + ((p >> 1) & 1);
      endcase
    end
    if (p > N_LEAD && p <= N_LEAD + N_EFF) return (p * 37 + seed * 101) % 4096;
    return 3000;
  endfunction

  task automatic put(input bit ov, input int op, input bit ev, input int ep);
    odd_vld   = ov;
    odd_pos   = POS_W'(op);
    odd_data  = DW'(ov ? sample_val(cur_kind, cur_seed, op) : 0);
    even_vld  = ev;
    even_pos  = POS_W'(ep);
    even_data = DW'(ev ? sample_val(cur_kind, cur_seed, ep) : 0);
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 0, 1'b0, 0);
  endtask

  // alt: 0 simultaneous, 1 alternate; skip_pos: position not sent (0 none);
  // stop_after: last position sent (0 = full line)
  task automatic drive_line(input bit alt, input int kind, input int seed,
                            input int skip_pos, input int stop_after, input bit expect_out);
    int sum_o, sum_e, mean_o, mean_e, last;
    cur_kind = kind;
    cur_seed = seed;
    sum_o = 0; sum_e = 0;
    for (int i = 0; i < 10; i++) begin
      sum_o += sample_val(kind, seed, 5 + 2 * i);
      sum_e += sample_val(kind, seed, 6 + 2 * i);
    end
    mean_o = (sum_o + 5) / 10;   // R3 rounding rule
    mean_e = (sum_e + 5) / 10;
    last = (stop_after != 0) ? stop_after : N_TOTAL;
    if (expect_out) begin
      for (int p = N_LEAD + 1; p <= N_LEAD + N_EFF && p <= last; p++) begin
        item_t it;
        int d, m;
        if (p == skip_pos) continue;
        if (skip_pos != 0 && (p % 2) == (skip_pos % 2) && p > skip_pos) continue;
        d = sample_val(kind, seed, p);
        m = (p % 2 == 1) ? mean_o : mean_e;
        it.num  = p - N_LEAD;
        it.data = (d > m) ? d - m : 0;
        if (p % 2 == 1) begin
          it.mark = (it.num == 1);
          q_odd.push_back(it);
        end else begin
          it.mark = (it.num == N_EFF);
          q_even.push_back(it);
        end
      end
    end
    line_start = 1'b1;
    put(1'b0, 0, 1'b0, 0);
    line_start = 1'b0;
    if (!alt) begin
      for (int s = 0; s < N_TOTAL / 2; s++) begin
        int po, pe;
        po = 2 * s + 1;
        pe = 2 * s + 2;
        put(po <= last && po != skip_pos, po, pe <= last && pe != skip_pos, pe);
      end
    end else begin
      for (int t = 0; t <= N_TOTAL / 2; t++) begin
        int po, pe;
        po = 2 * t + 1;
        pe = 2 * t;
        put(t < N_TOTAL / 2 && po <= last && po != skip_pos, po,
            t >= 1 && pe <= last && pe != skip_pos, pe);
      end
    end
    idle(4);
  endtask

  task automatic drained(input string req);
    check(q_odd.size() == 0, req, q_odd.size(), 0, "odd lane pixels missing");
    check(q_even.size() == 0, req, q_even.size(), 0, "even lane pixels missing");
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_odd_vld) begin
        if (q_odd.size() == 0) check(1'b0, {tag, " R5"}, int'(out_odd_num), 0, "unexpected odd pixel");
        else begin
          item_t it;
          it = q_odd.pop_front();
          check(int'(out_odd_num) == it.num, {tag, " R5"}, int'(out_odd_num), it.num, "odd number");
          check(out_odd_num[0] == 1'b1, {tag, " R2"}, int'(out_odd_num), it.num, "odd lane parity");
          check(int'(out_odd_data) == it.data, {tag, " R4"}, int'(out_odd_data), it.data, "odd data");
          check(out_sol == it.mark, {tag, " R6"}, int'(out_sol), int'(it.mark), "start marker");
        end
      end else if (out_sol) check(1'b0, "R6", 1, 0, "start marker without pixel");
      if (out_even_vld) begin
        if (q_even.size() == 0) check(1'b0, {tag, " R5"}, int'(out_even_num), 0, "unexpected even pixel");
        else begin
          item_t it;
          it = q_even.pop_front();
          check(int'(out_even_num) == it.num, {tag, " R5"}, int'(out_even_num), it.num, "even number");
          check(out_even_num[0] == 1'b0, {tag, " R2"}, int'(out_even_num), it.num, "even lane parity");
          check(int'(out_even_data) == it.data, {tag, " R4"}, int'(out_even_data), it.data, "even data");
          check(out_eol == it.mark, {tag, " R6"}, int'(out_eol), int'(it.mark), "end marker");
        end
      end else if (out_eol) check(1'b0, "R6", 1, 0, "end marker without pixel");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1, "run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic reset_check;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_odd_vld && !out_even_vld, "R10", int'(out_odd_vld) + int'(out_even_vld), 0, "valid in reset");
    check(!out_sol && !out_eol, "R10", int'(out_sol) + int'(out_eol), 0, "markers in reset");
    check(!seq_err, "R10", int'(seq_err), 0, "error in reset");
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    check(!seq_err && !out_odd_vld && !out_even_vld, "R10", int'(seq_err), 0, "state after reset");
    @(posedge clk); #2;
  endtask

  initial begin
    reset_check();

    // R9: samples before any line start are ignored
    tag = "R9";
    for (int i = 0; i < 6; i++) put(1'b1, 75 + 2 * i, 1'b1, 76 + 2 * i);
    idle(3);
    check(!seq_err, "R9", int'(seq_err), 0, "error before first line start");
    drained("R9");

    tag = "R1";
    drive_line(1'b0, 0, 1, 0, 0, 1'b1);
    drained("R1");
    check(!seq_err, "R8", int'(seq_err), 0, "error on clean simultaneous line");

    tag = "R7";
    drive_line(1'b1, 0, 1, 0, 0, 1'b1);
    drained("R7");
    check(!seq_err, "R8", int'(seq_err), 0, "error on clean alternate line");

    tag = "R4";
    drive_line(1'b0, 1, 2, 0, 0, 1'b1);
    drive_line(1'b1, 2, 3, 0, 0, 1'b1);
    drained("R4");

    tag = "R3";
    drive_line(1'b1, 3, 4, 0, 0, 1'b1);
    drained("R3");

    // R8: skipped odd position
    tag = "R8";
    drive_line(1'b0, 0, 5, 201, 0, 1'b1);
    drained("R8");
    check(seq_err, "R8", int'(seq_err), 1, "skip not flagged");

    tag = "R9";
    drive_line(1'b1, 0, 6, 0, 0, 1'b1);
    drained("R9");
    check(seq_err, "R8", int'(seq_err), 1, "flag not sticky");

    reset_check();
    tag = "R8";
    drive_line(1'b0, 0, 7, 0, 300, 1'b1);
    drained("R8");
    check(!seq_err, "R8", int'(seq_err), 0, "flag before early line start");
    tag = "R9";
    drive_line(1'b0, 0, 8, 0, 0, 1'b1);
    drained("R9");
    check(seq_err, "R8", int'(seq_err), 1, "early end not flagged");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule